// File: doc/BRIEF.md
# Parallel converter read controller

This block sits on the host side of a 12-bit successive-approximation converter that has a parallel, byte-selectable output bus. When a sample request arrives, the controller pulls the convert line and the chip select low for a fixed number of cycles. It releases both while the converter still reports a conversion in progress, then waits for the converter's idle line to rise. It then enables the bus and reads the result, either as one 12-bit word or as two byte reads, depending on a mode parameter. The code is two's complement and is sign-extended to 16 bits.

The result and a timeout flag are offered on a valid/ready output. The output holds its value until the consumer takes it. The consumer may hold ready low for as long as it likes. While it does, data and flag stay frozen and no new conversion begins. A request that arrives too soon after the previous start is remembered and launched as soon as the minimum start-to-start spacing has elapsed. All timing figures are given in nanoseconds and turned into cycle counts from the clock period parameter.

Top module: `adc_rdctl`

## Requirements
- R1: While reset is asserted and directly after it, `cnv_n` and `sel_n` are high, `hbyte` is low and `res_valid` is low.
- R2: A conversion begins with `cnv_n` and `sel_n` going low in the same cycle. They stay low for exactly PULSE_CYC = ceil(PULSE_NS/CLK_NS) cycles and then return high together.
- R3: Two falling edges of `cnv_n` are at least SPACE_CYC = ceil(SPACE_NS/CLK_NS) cycles apart. A request held back by this rule starts exactly SPACE_CYC cycles after the previous start.
- R4: Any number of requests that arrive while one request is already waiting merge into a single further conversion.
- R5: After `conv_idle` rises, the bus is enabled (`sel_n` low, `cnv_n` high, `hbyte` low). The bus is sampled only after it has been enabled, with an unchanged `hbyte`, for ACC_CYC = ceil(ACC_NS/CLK_NS) cycles.
- R6: With BYTE_MODE = 0, `res_data` equals `bus_i[11:0]` with bit 11 copied into bits 15:12.
- R7: With BYTE_MODE = 1, the first read (`hbyte` = 0) takes `bus_i[11:4]` as result bits 11:4. `hbyte` then goes high and, after another ACC_CYC cycles, `bus_i[11:8]` is taken as bits 3:0. The result is sign-extended from bit 11.
- R8: If `conv_idle` has not risen TMO_CYC cycles after the release of `cnv_n`, a result is offered with `res_tmo` = 1 and `res_data` = 0.
- R9: While `res_valid` is high and `res_ready` is low, `res_valid`, `res_data` and `res_tmo` stay unchanged. A transfer happens on a cycle where both are high, and `res_valid` drops in the next cycle.
- R10: `cnv_n` returns high while `conv_idle` is still low, so the converter never starts a second conversion without a new pulse.
- R11: `sel_n` stays high while a conversion is running with `cnv_n` high, and while a result is offered. `hbyte` is high only while the bus is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_req | input | 1 | One-cycle sample request |
| res_valid | output | 1 | Result offered |
| res_ready | input | 1 | Consumer accepts result |
| res_data | output | 16 | Sign-extended conversion code |
| res_tmo | output | 1 | Result is a timeout, not a code |
| cnv_n | output | 1 | Convert line, low starts a conversion |
| sel_n | output | 1 | Converter chip select, active low |
| hbyte | output | 1 | Byte select: 0 upper bits, 1 lower bits |
| conv_idle | input | 1 | Converter idle; rises when the result is ready |
| bus_i | input | 12 | Converter parallel data lines |

## Verification
Two things can land in the same cycle: the spacing window expiring while a request is waiting, and a result still sitting unaccepted on the output. The bench holds `res_ready` low for a varying number of cycles while new requests are queued. It then checks that each held request starts exactly SPACE_CYC cycles after the previous start. It also checks that the offered result stayed frozen throughout. A word-mode and a byte-mode instance run in lockstep against converter models. Each model drives a garbage pattern until its bus has been stable for the access time, so sampling too early shows up as a wrong code.

// File: rtl/adc_rdctl_pkg.sv
package adc_rdctl_pkg;

  localparam int CODE_W = 12;
  localparam int OUT_W  = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PULSE,
    ST_WAIT,
    ST_RDHI,
    ST_RDLO,
    ST_OUT
  } rd_state_t;

  function automatic int ns2cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/adc_rdctl_pace.sv
module adc_rdctl_pace #(
  parameter int SPACE_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic launch_i,
  output logic pend_o,
  output logic open_o
);
  localparam int SW = $clog2(SPACE_CYC + 1);
  localparam logic [SW-1:0] SPACE_LD = SW'(SPACE_CYC - 1);

  logic [SW-1:0] gap_q;
  logic          pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~launch_i) | req_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
    end else if (launch_i) begin
      gap_q <= SPACE_LD;
    end else if (gap_q != '0) begin
      gap_q <= gap_q - 1'b1;
    end
  end

  assign pend_o = pend_q;
  assign open_o = (gap_q == '0);

endmodule

// File: rtl/adc_rdctl_seq.sv
module adc_rdctl_seq
  import adc_rdctl_pkg::*;
#(
  parameter int PULSE_CYC = 10,
  parameter int TMO_CYC   = 1200,
  parameter int ACC_CYC   = 9,
  parameter bit BYTE_MODE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pend_i,
  input  logic open_i,
  input  logic conv_idle,
  input  logic res_ready,
  output logic launch_o,
  output logic cap_word_o,
  output logic cap_hi_o,
  output logic cap_lo_o,
  output logic tmo_o,
  output logic res_valid,
  output logic cnv_n,
  output logic sel_n,
  output logic hbyte
);
  localparam int MAXC = (PULSE_CYC > TMO_CYC) ?
                        ((PULSE_CYC > ACC_CYC) ? PULSE_CYC : ACC_CYC) :
                        ((TMO_CYC > ACC_CYC) ? TMO_CYC : ACC_CYC);
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PULSE_LD = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] TMO_LD   = CW'(TMO_CYC - 1);
  localparam logic [CW-1:0] ACC_LD   = CW'(ACC_CYC - 1);

  rd_state_t     st_q;
  logic [CW-1:0] cnt_q;
  logic          cnv_q, sel_q, hb_q;
  logic          last;

  assign last       = (cnt_q == '0);
  assign launch_o   = (st_q == ST_IDLE) && pend_i && open_i;
  assign cap_word_o = (st_q == ST_RDHI) && last && !BYTE_MODE;
  assign cap_hi_o   = (st_q == ST_RDHI) && last && BYTE_MODE;
  assign cap_lo_o   = (st_q == ST_RDLO) && last;
  assign tmo_o      = (st_q == ST_WAIT) && !conv_idle && last;
  assign res_valid  = (st_q == ST_OUT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      cnv_q <= 1'b1;
      sel_q <= 1'b1;
      hb_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (launch_o) begin
          st_q  <= ST_PULSE;
          cnt_q <= PULSE_LD;
          cnv_q <= 1'b0;
          sel_q <= 1'b0;
        end
        ST_PULSE: if (last) begin
          st_q  <= ST_WAIT;
          cnt_q <= TMO_LD;
          cnv_q <= 1'b1;
          sel_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        ST_WAIT: if (conv_idle) begin
          st_q  <= ST_RDHI;
          cnt_q <= ACC_LD;
          sel_q <= 1'b0;
          hb_q  <= 1'b0;
        end else if (last) begin
          st_q <= ST_OUT;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        ST_RDHI: if (last) begin
          if (BYTE_MODE) begin
            st_q  <= ST_RDLO;
            cnt_q <= ACC_LD;
            hb_q  <= 1'b1;
          end else begin
            st_q  <= ST_OUT;
            sel_q <= 1'b1;
          end
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        ST_RDLO: if (last) begin
          st_q  <= ST_OUT;
          sel_q <= 1'b1;
          hb_q  <= 1'b0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        ST_OUT: if (res_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cnv_n = cnv_q;
  assign sel_n = sel_q;
  assign hbyte = hb_q;

endmodule

// File: rtl/adc_rdctl_asm.sv
module adc_rdctl_asm
  import adc_rdctl_pkg::*;
#(
  parameter bit BYTE_MODE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              cap_word_i,
  input  logic              cap_hi_i,
  input  logic              cap_lo_i,
  input  logic              tmo_i,
  input  logic [CODE_W-1:0] bus_i,
  output logic [OUT_W-1:0]  res_data,
  output logic              res_tmo
);
  localparam int LO_W  = CODE_W - BYTE_W;
  localparam int EXT_W = OUT_W - CODE_W;

  logic [CODE_W-1:0] code_q;
  logic              tmo_q;

  generate
    if (BYTE_MODE) begin : g_byte
      logic unused_lines;
      assign unused_lines = ^bus_i[LO_W-1:0] ^ cap_word_i;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          code_q <= '0;
        end else if (clr_i) begin
          code_q <= '0;
        end else begin
          if (cap_hi_i) code_q[CODE_W-1:LO_W] <= bus_i[CODE_W-1 -: BYTE_W];
          if (cap_lo_i) code_q[LO_W-1:0]      <= bus_i[CODE_W-1 -: LO_W];
        end
      end
    end else begin : g_word
      logic unused_strobes;
      assign unused_strobes = cap_hi_i ^ cap_lo_i;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          code_q <= '0;
        end else if (clr_i) begin
          code_q <= '0;
        end else if (cap_word_i) begin
          code_q <= bus_i;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_q <= 1'b0;
    end else if (clr_i) begin
      tmo_q <= 1'b0;
    end else if (tmo_i) begin
      tmo_q <= 1'b1;
    end
  end

  assign res_data = {{EXT_W{code_q[CODE_W-1]}}, code_q};
  assign res_tmo  = tmo_q;

endmodule

// File: rtl/adc_rdctl.sv
module adc_rdctl
  import adc_rdctl_pkg::*;
#(
  parameter int CLK_NS    = 10,
  parameter int PULSE_NS  = 100,
  parameter int SPACE_NS  = 10000,
  parameter int TMO_NS    = 12000,
  parameter int ACC_NS    = 83,
  parameter bit BYTE_MODE = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        smp_req,
  output logic        res_valid,
  input  logic        res_ready,
  output logic [15:0] res_data,
  output logic        res_tmo,
  output logic        cnv_n,
  output logic        sel_n,
  output logic        hbyte,
  input  logic        conv_idle,
  input  logic [11:0] bus_i
);
  localparam int PULSE_CYC = ns2cyc(PULSE_NS, CLK_NS);
  localparam int SPACE_CYC = ns2cyc(SPACE_NS, CLK_NS);
  localparam int TMO_CYC   = ns2cyc(TMO_NS, CLK_NS);
  localparam int ACC_CYC   = ns2cyc(ACC_NS, CLK_NS);

  logic pend, open_win, launch;
  logic cap_word, cap_hi, cap_lo, tmo;

  adc_rdctl_pace #(.SPACE_CYC(SPACE_CYC)) u_pace (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (smp_req),
    .launch_i (launch),
    .pend_o   (pend),
    .open_o   (open_win)
  );

  adc_rdctl_seq #(
    .PULSE_CYC (PULSE_CYC),
    .TMO_CYC   (TMO_CYC),
    .ACC_CYC   (ACC_CYC),
    .BYTE_MODE (BYTE_MODE)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend_i     (pend),
    .open_i     (open_win),
    .conv_idle  (conv_idle),
    .res_ready  (res_ready),
    .launch_o   (launch),
    .cap_word_o (cap_word),
    .cap_hi_o   (cap_hi),
    .cap_lo_o   (cap_lo),
    .tmo_o      (tmo),
    .res_valid  (res_valid),
    .cnv_n      (cnv_n),
    .sel_n      (sel_n),
    .hbyte      (hbyte)
  );

  adc_rdctl_asm #(.BYTE_MODE(BYTE_MODE)) u_asm (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (launch),
    .cap_word_i (cap_word),
    .cap_hi_i   (cap_hi),
    .cap_lo_i   (cap_lo),
    .tmo_i      (tmo),
    .bus_i      (bus_i),
    .res_data   (res_data),
    .res_tmo    (res_tmo)
  );

endmodule

// File: rtl/adc_rdctl_chk.sv
module adc_rdctl_chk #(
  parameter int SPACE_CYC = 1000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cnv_n,
  input logic        sel_n,
  input logic        hbyte,
  input logic        conv_idle,
  input logic        res_valid,
  input logic        res_ready,
  input logic [15:0] res_data,
  input logic        res_tmo
);
  localparam int GW = $clog2(SPACE_CYC + 1);
  localparam logic [GW-1:0] GAP_FULL = GW'(SPACE_CYC);

  logic [GW-1:0] gap_q;
  logic          cnv_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnv_d <= 1'b1;
      gap_q <= GAP_FULL;
    end else begin
      cnv_d <= cnv_n;
      if (cnv_d && !cnv_n) gap_q <= GW'(1);
      else if (gap_q != GAP_FULL) gap_q <= gap_q + 1'b1;
    end
  end

  // R2: convert line low only with the chip selected
  p_pulse_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cnv_n |-> !sel_n);

  // R3: a new start only once the spacing window is full
  p_space_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnv_d && !cnv_n) |-> (gap_q == GAP_FULL));

  // R9: offered result frozen under back-pressure
  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_tmo)));

  // R10: release happens while the converter is still busy
  p_release_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv_n) |-> !$past(conv_idle));

  // R11: bus stays off while converting and while a result waits
  p_bus_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cnv_n && !conv_idle) || res_valid |-> sel_n);

  // R11: byte select only on an enabled bus
  p_hbyte_enabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hbyte |-> (!sel_n && cnv_n));

endmodule

bind adc_rdctl adc_rdctl_chk #(.SPACE_CYC(SPACE_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnv_n     (cnv_n),
  .sel_n     (sel_n),
  .hbyte     (hbyte),
  .conv_idle (conv_idle),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_data  (res_data),
  .res_tmo   (res_tmo)
);

// File: tb/adc_rdctl_test.sv
module adc_rdctl_cvt_model #(
  parameter int CONV_CYC = 20,
  parameter int ACC_CYC  = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cnv_n,
  input  logic        sel_n,
  input  logic        hbyte,
  input  logic [11:0] code,
  input  logic        stall,
  output logic        conv_idle,
  output logic [11:0] bus,
  output int          nstart
);
  logic        idle_q, en, en_d, hb_d, ok;
  logic [11:0] held;
  int          cnt, age;

  always_comb en = !sel_n && cnv_n;
  always_comb ok = en && en_d && (hbyte == hb_d) && (age >= ACC_CYC - 2);
  always_comb begin
    if (!ok)        bus = 12'h5A5;
    else if (hbyte) bus = {held[3:0], 4'h0, held[11:8]};
    else            bus = held;
  end
  assign conv_idle = idle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= 1'b1; cnt <= 0; held <= '0; age <= 0;
      en_d <= 1'b0; hb_d <= 1'b0; nstart <= 0;
    end else begin
      if (idle_q && !cnv_n && !sel_n) begin
        idle_q <= 1'b0; cnt <= 0; held <= code; nstart <= nstart + 1;
      end else if (!idle_q && !stall) begin
        if (cnt == CONV_CYC - 1) idle_q <= 1'b1;
        else cnt <= cnt + 1;
      end
      if (en && en_d && hbyte == hb_d) age <= (age < 100) ? age + 1 : age;
      else age <= 0;
      en_d <= en;
      hb_d <= hbyte;
    end
  end
endmodule

module adc_rdctl_mon #(
  parameter int PULSE_CYC = 5,
  parameter int SPACE_CYC = 60
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cnv_n,
  input  logic        sel_n,
  input  logic        hbyte,
  input  logic        conv_idle,
  input  logic        res_valid,
  input  logic        res_ready,
  input  logic [15:0] res_data,
  input  logic        res_tmo,
  input  logic        exp_held,
  output int          nchk,
  output int          nfail,
  output int          nfall
);
  int          cyc, last_fall;
  logic        p_cnv, p_valid, p_ready, p_tmo;
  logic [15:0] p_data;

  initial begin
    nchk = 0; nfail = 0; nfall = 0; cyc = 0; last_fall = -1;
    p_cnv = 1'b1; p_valid = 1'b0; p_ready = 1'b0; p_tmo = 1'b0; p_data = '0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      cyc = cyc + 1;
      if (p_cnv && !cnv_n) begin
        nfall = nfall + 1;
        nchk = nchk + 1;
        if (sel_n) begin nfail++; $display("FAIL R2: sel_n=%0b at pulse start, expected 0", sel_n); end
        if (last_fall >= 0) begin
          nchk = nchk + 1;
          if (cyc - last_fall < SPACE_CYC || (exp_held && cyc - last_fall != SPACE_CYC)) begin
            nfail++; $display("FAIL R3: start gap %0d, expected %0d", cyc - last_fall, SPACE_CYC);
          end
        end
        last_fall = cyc;
      end
      if (!p_cnv && cnv_n) begin
        nchk = nchk + 1;
        if (cyc - last_fall != PULSE_CYC) begin
          nfail++; $display("FAIL R2: pulse %0d cycles, expected %0d", cyc - last_fall, PULSE_CYC);
        end
        nchk = nchk + 1;
        if (!sel_n) begin nfail++; $display("FAIL R2: sel_n=0 after release, expected 1"); end
        nchk = nchk + 1;
        if (conv_idle) begin nfail++; $display("FAIL R10: conv_idle=1 at release, expected 0"); end
      end
      if (p_valid && !p_ready) begin
        nchk = nchk + 1;
        if (!res_valid || res_data != p_data || res_tmo != p_tmo) begin
          nfail++;
          $display("FAIL R9: held output v=%0b d=%h t=%0b, expected v=1 d=%h t=%0b",
                   res_valid, res_data, res_tmo, p_data, p_tmo);
        end
      end
      if ((cnv_n && !conv_idle) || res_valid) begin
        nchk = nchk + 1;
        if (!sel_n) begin nfail++; $display("FAIL R11: sel_n=0 while quiet, expected 1"); end
      end
      if (hbyte) begin
        nchk = nchk + 1;
        if (sel_n || !cnv_n) begin nfail++; $display("FAIL R11: hbyte=1 with sel_n=%0b cnv_n=%0b, expected 0/1", sel_n, cnv_n); end
      end
      p_cnv = cnv_n; p_valid = res_valid; p_ready = res_ready; p_data = res_data; p_tmo = res_tmo;
    end
  end
endmodule

module adc_rdctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE_CYC  = 5;
  localparam int SPACE_CYC  = 60;
  localparam int CONV_CYC   = 20;
  localparam int ACC_CYC    = 3;

  logic clk, rst_n, smp_req, res_ready, stall, held_mode;
  logic [11:0] code;
  logic        v_w, v_b, t_w, t_b, cn_w, cn_b, sl_w, sl_b, hb_w, hb_b, id_w, id_b;
  logic [15:0] d_w, d_b;
  logic [11:0] bus_w, bus_b;
  int ns_w, ns_b, mc_w, mf_w, fl_w, mc_b, mf_b, fl_b;
  int nchk, nfail;
  bit done;

  initial begin clk = 1'b0; forever #(CLK_PERIOD/2) clk = ~clk; end

  adc_rdctl #(.CLK_NS(CLK_PERIOD), .PULSE_NS(50), .SPACE_NS(600), .TMO_NS(400),
              .ACC_NS(30), .BYTE_MODE(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .smp_req(smp_req), .res_valid(v_w), .res_ready(res_ready),
    .res_data(d_w), .res_tmo(t_w), .cnv_n(cn_w), .sel_n(sl_w), .hbyte(hb_w),
    .conv_idle(id_w), .bus_i(bus_w));

  adc_rdctl #(.CLK_NS(CLK_PERIOD), .PULSE_NS(50), .SPACE_NS(600), .TMO_NS(400),
              .ACC_NS(30), .BYTE_MODE(1'b1)) uut_b (
    .clk(clk), .rst_n(rst_n), .smp_req(smp_req), .res_valid(v_b), .res_ready(res_ready),
    .res_data(d_b), .res_tmo(t_b), .cnv_n(cn_b), .sel_n(sl_b), .hbyte(hb_b),
    .conv_idle(id_b), .bus_i(bus_b));

  adc_rdctl_cvt_model #(.CONV_CYC(CONV_CYC), .ACC_CYC(ACC_CYC)) m_w (
    .clk(clk), .rst_n(rst_n), .cnv_n(cn_w), .sel_n(sl_w), .hbyte(hb_w), .code(code),
    .stall(stall), .conv_idle(id_w), .bus(bus_w), .nstart(ns_w));
  adc_rdctl_cvt_model #(.CONV_CYC(CONV_CYC), .ACC_CYC(ACC_CYC)) m_b (
    .clk(clk), .rst_n(rst_n), .cnv_n(cn_b), .sel_n(sl_b), .hbyte(hb_b), .code(code),
    .stall(stall), .conv_idle(id_b), .bus(bus_b), .nstart(ns_b));

  adc_rdctl_mon #(.PULSE_CYC(PULSE_CYC), .SPACE_CYC(SPACE_CYC)) mon_w (
    .clk(clk), .rst_n(rst_n), .cnv_n(cn_w), .sel_n(sl_w), .hbyte(hb_w), .conv_idle(id_w),
    .res_valid(v_w), .res_ready(res_ready), .res_data(d_w), .res_tmo(t_w),
    .exp_held(held_mode), .nchk(mc_w), .nfail(mf_w), .nfall(fl_w));
  adc_rdctl_mon #(.PULSE_CYC(PULSE_CYC), .SPACE_CYC(SPACE_CYC)) mon_b (
    .clk(clk), .rst_n(rst_n), .cnv_n(cn_b), .sel_n(sl_b), .hbyte(hb_b), .conv_idle(id_b),
    .res_valid(v_b), .res_ready(res_ready), .res_data(d_b), .res_tmo(t_b),
    .exp_held(held_mode), .nchk(mc_b), .nfail(mf_b), .nfall(fl_b));

  function automatic logic [15:0] sx(input logic [11:0] c);
    return {{4{c[11]}}, c};
  endfunction

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk + mc_w + mc_b, nfail + mf_w + mf_b);
      $finish;
    end
  endtask

  task automatic take(input logic [11:0] c, input bit exp_tmo, input int hold);
    int n = 0;
    while (!(v_w && v_b) && n < 400) begin @(negedge clk); n++; end
    check(v_w && v_b, "R9 result offered", {v_w, v_b}, 2'b11);
    if (exp_tmo) begin
      check(t_w && d_w == 16'h0, "R8 word timeout", {t_w, d_w}, {1'b1, 16'h0});
      check(t_b && d_b == 16'h0, "R8 byte timeout", {t_b, d_b}, {1'b1, 16'h0});
    end else begin
      check(!t_w && d_w == sx(c), "R6 R5 word code", {t_w, d_w}, {1'b0, sx(c)});
      check(!t_b && d_b == sx(c), "R7 R5 byte code", {t_b, d_b}, {1'b0, sx(c)});
    end
    repeat (hold) @(negedge clk);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    check(!v_w && !v_b, "R9 valid drops after transfer", {v_w, v_b}, 2'b00);
  endtask

  task automatic convert(input logic [11:0] c, input bit exp_tmo, input int hold);
    code = c;
    smp_req = 1'b1;
    @(negedge clk);
    smp_req = 1'b0;
    take(c, exp_tmo, hold);
  endtask

  initial begin
    done = 1'b0;
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    report();
  end

  initial begin
    int f0;
    nchk = 0; nfail = 0;
    rst_n = 1'b0; smp_req = 1'b0; res_ready = 1'b0; code = '0; stall = 1'b0; held_mode = 1'b0;
    repeat (4) @(negedge clk);
    // R1: reset state on both instances
    check(cn_w && sl_w && !hb_w && !v_w, "R1 word reset", {cn_w, sl_w, hb_w, v_w}, 4'b1100);
    check(cn_b && sl_b && !hb_b && !v_b, "R1 byte reset", {cn_b, sl_b, hb_b, v_b}, 4'b1100);
    rst_n = 1'b1;
    @(negedge clk);
    check(cn_w && sl_w && !v_w && !v_b, "R1 after release", {cn_w, sl_w, v_w, v_b}, 4'b1100);

    // R6 R7 R3 R9: code sweep, each request held by the spacing window
    convert(12'h000, 1'b0, 0);
    held_mode = 1'b1;
    for (int k = 0; k < 256; k++) begin
      convert(12'((k << 4) | ((k * 7) & 15)), 1'b0, k % 4);
    end
    convert(12'h7FF, 1'b0, 2);
    convert(12'h800, 1'b0, 0);
    convert(12'hFFF, 1'b0, 1);
    convert(12'h001, 1'b0, 3);
    held_mode = 1'b0;

    // R4: three requests in quick succession give one extra conversion
    repeat (80) @(negedge clk);
    f0 = fl_w;
    code = 12'h9A3;
    for (int i = 0; i < 3; i++) begin
      smp_req = 1'b1; @(negedge clk); smp_req = 1'b0; repeat (2) @(negedge clk);
    end
    take(12'h9A3, 1'b0, 5);
    take(12'h9A3, 1'b0, 0);
    repeat (150) @(negedge clk);
    check(fl_w - f0 == 2, "R4 merged starts", fl_w - f0, 2);

    // R8: converter never completes
    stall = 1'b1;
    convert(12'h3C5, 1'b1, 2);
    repeat (10) @(negedge clk);
    stall = 1'b0;
    repeat (80) @(negedge clk);
    convert(12'hC3A, 1'b0, 1);
    repeat (100) @(negedge clk);

    // R10: converter started exactly once per pulse
    check(ns_w == fl_w, "R10 word starts", ns_w, fl_w);
    check(ns_b == fl_b, "R10 byte starts", ns_b, fl_b);
    report();
  end
endmodule